// File: doc/BRIEF.md
# Power Source Transfer Sequencer

This block sits between the logic that chooses a power source and the drivers that switch it. It handles two supply rails. Each rail can be fed from a main source or from a standby source. For each rail the block takes a level request, "use main" or "use standby", and an off request. It turns them into registered enable pins for the two driver stages of that rail. All timing comes from cycle counters whose lengths are parameters.

The two rails follow opposite transfer orders:

- **Switched rail.** The main switch and the standby regulator would feed each other if both were on. The block therefore drops the outgoing enable first. It holds both enables low for a fixed dead time, then raises the incoming enable.
- **Memory rail.** This rail must never lose its supply. The block raises the incoming enable first. It holds both sources on for a fixed overlap time, then drops the outgoing one.

When a rail is off and a source is requested, that source turns on at once, with no sequencing. An off request clears both enables of its rail in the next cycle. If that off request cuts short a transfer, the block reports it on a one-cycle abort pulse for that rail. A busy output is high while either rail is in a transfer.

The parameter windows are checked at elaboration. The dead time must lie inside its minimum and maximum, and the overlap must lie inside its own limits. The maximum overlap keeps the standby source from carrying main-level load for long. The maximum dead time bounds the hold-up that the output capacitor must supply.

Top module: `src_transfer_seq`

## Requirements
- R1: While `rst` is high, all four enables, `busy` and both `xfer_abort` bits are low one cycle after the first clock edge.
- R2: When a rail is off and its off request is low, the enable named by its request rises one cycle after the request is sampled, with no dead time or overlap. The request is 1 for main and 0 for standby. `busy` stays low for that turn-on.
- R3: `sw_main_en` and `sw_stby_en` are never high in the same cycle.
- R4: When the switched-rail request changes in steady state, the outgoing enable falls one cycle after the request is sampled. Both enables then stay low for exactly `DEAD_CYC` cycles, and the incoming enable rises in the cycle after that.
- R5: When the memory-rail request changes in steady state, the incoming enable rises one cycle after the request is sampled. Both enables stay high for exactly `OVL_CYC` cycles, and the outgoing enable falls in the cycle after that.
- R6: On the memory rail, if an enable is high and the off request is low, then an enable is still high in the next cycle.
- R7: A request change during a transfer does not alter that transfer. After the transfer completes, the rail starts a new transfer in the next cycle if the request then names the other source.
- R8: An off request clears both enables of its rail one cycle after it is sampled, whatever state the rail is in. It overrides the source request for as long as it is held.
- R9: `xfer_abort` bit 0 (switched rail) or bit 1 (memory rail) pulses high for one cycle when an off request ends a transfer of that rail. An off request in steady state leaves the bit low.
- R10: `busy` is high exactly in the cycles in which either rail is in a transfer: from one cycle after the transfer starts through the cycle before its last enable change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_main_req | input | 1 | Switched rail source request: 1 main, 0 standby |
| sw_off_req | input | 1 | Switched rail off request |
| mem_main_req | input | 1 | Memory rail source request: 1 main, 0 standby |
| mem_off_req | input | 1 | Memory rail off request |
| sw_main_en | output | 1 | Switched rail main switch enable |
| sw_stby_en | output | 1 | Switched rail standby regulator enable |
| mem_main_en | output | 1 | Memory rail main driver enable |
| mem_stby_en | output | 1 | Memory rail standby regulator enable |
| busy | output | 1 | A transfer is in progress on either rail |
| xfer_abort | output | 2 | One-cycle pulse when an off request ends a transfer: bit 0 switched rail, bit 1 memory rail |

## Verification
A wrong rail state shows up at the enables in the cycle after the edge that took it. A rail stuck in its transfer state leaves `busy` high past the expected completion cycle. A miscounted timer moves the rising or falling enable edge off its exact cycle. A lost target register makes the rail finish on the wrong source. Every transfer length and turn-on cycle is therefore compared at the single cycle where it must change, and the exclusion and continuity rules are checked on every cycle.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef enum logic [1:0] {
    RAIL_OFF  = 2'd0,
    RAIL_STBY = 2'd1,
    RAIL_MAIN = 2'd2,
    RAIL_MOVE = 2'd3
  } rail_state_e;
endpackage

// File: rtl/xfer_timer.sv
module xfer_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rail_xfer.sv
module rail_xfer
  import xfer_seq_pkg::*;
#(
  parameter bit MAKE_FIRST = 1'b0,  // 1: overlap transfer, 0: break-before-make
  parameter int HOLD_CYC   = 4,
  parameter int CNT_W      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic want_main,
  input  logic off_req,
  output logic main_en,
  output logic stby_en,
  output logic moving,
  output logic abort
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(HOLD_CYC - 1);

  rail_state_e state;
  logic        dest_main;
  logic        start;
  logic        expired;
  logic        start_lvl;

  // Level both enables take while the transfer window is open.
  generate
    if (MAKE_FIRST) begin : g_make
      assign start_lvl = 1'b1;
    end else begin : g_break
      assign start_lvl = 1'b0;
    end
  endgenerate

  assign start = !off_req &&
                 (((state == RAIL_STBY) && want_main) ||
                  ((state == RAIL_MAIN) && !want_main));

  xfer_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (LOAD_VAL),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RAIL_OFF;
      dest_main <= 1'b0;
      main_en   <= 1'b0;
      stby_en   <= 1'b0;
      moving    <= 1'b0;
      abort     <= 1'b0;
    end else begin
      abort <= 1'b0;
      if (off_req) begin
        abort   <= (state == RAIL_MOVE);
        state   <= RAIL_OFF;
        main_en <= 1'b0;
        stby_en <= 1'b0;
        moving  <= 1'b0;
      end else begin
        unique case (state)
          RAIL_OFF: begin
            state   <= want_main ? RAIL_MAIN : RAIL_STBY;
            main_en <= want_main;
            stby_en <= !want_main;
          end
          RAIL_STBY, RAIL_MAIN: begin
            if (start) begin
              state     <= RAIL_MOVE;
              dest_main <= want_main;
              main_en   <= start_lvl;
              stby_en   <= start_lvl;
              moving    <= 1'b1;
            end
          end
          RAIL_MOVE: begin
            if (expired) begin
              state   <= dest_main ? RAIL_MAIN : RAIL_STBY;
              main_en <= dest_main;
              stby_en <= !dest_main;
              moving  <= 1'b0;
            end
          end
          default: state <= RAIL_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/src_transfer_seq.sv
module src_transfer_seq #(
  parameter int DEAD_CYC     = 50,
  parameter int DEAD_MIN_CYC = 25,
  parameter int DEAD_MAX_CYC = 1500,
  parameter int OVL_CYC      = 260,
  parameter int OVL_MIN_CYC  = 250,
  parameter int OVL_MAX_CYC  = 1250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_main_req,
  input  logic       sw_off_req,
  input  logic       mem_main_req,
  input  logic       mem_off_req,
  output logic       sw_main_en,
  output logic       sw_stby_en,
  output logic       mem_main_en,
  output logic       mem_stby_en,
  output logic       busy,
  output logic [1:0] xfer_abort
);
  localparam int LIMIT = (DEAD_MAX_CYC > OVL_MAX_CYC) ? DEAD_MAX_CYC : OVL_MAX_CYC;
  localparam int CNT_W = $clog2(LIMIT + 1);

  // Elaboration-time window checks on the timing parameters.
  generate
    if (DEAD_CYC < 1 || DEAD_CYC < DEAD_MIN_CYC || DEAD_CYC > DEAD_MAX_CYC) begin : g_bad_dead
      $error("DEAD_CYC outside its allowed window");
    end
    if (OVL_CYC < 1 || OVL_CYC < OVL_MIN_CYC || OVL_CYC > OVL_MAX_CYC) begin : g_bad_ovl
      $error("OVL_CYC outside its allowed window");
    end
  endgenerate

  logic sw_moving, mem_moving;
  logic sw_abort, mem_abort;

  rail_xfer #(.MAKE_FIRST(1'b0), .HOLD_CYC(DEAD_CYC), .CNT_W(CNT_W)) u_sw (
    .clk       (clk),
    .rst       (rst),
    .want_main (sw_main_req),
    .off_req   (sw_off_req),
    .main_en   (sw_main_en),
    .stby_en   (sw_stby_en),
    .moving    (sw_moving),
    .abort     (sw_abort)
  );

  rail_xfer #(.MAKE_FIRST(1'b1), .HOLD_CYC(OVL_CYC), .CNT_W(CNT_W)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .want_main (mem_main_req),
    .off_req   (mem_off_req),
    .main_en   (mem_main_en),
    .stby_en   (mem_stby_en),
    .moving    (mem_moving),
    .abort     (mem_abort)
  );

  assign busy       = sw_moving | mem_moving;
  assign xfer_abort = {mem_abort, sw_abort};
endmodule

// File: rtl/src_transfer_seq_chk.sv
module src_transfer_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sw_off_req,
  input logic       mem_off_req,
  input logic       sw_main_en,
  input logic       sw_stby_en,
  input logic       mem_main_en,
  input logic       mem_stby_en,
  input logic [1:0] xfer_abort
);
  assert_sw_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    !(sw_main_en && sw_stby_en));

  assert_mem_keep_R6: assert property (@(posedge clk) disable iff (rst)
    ((mem_main_en || mem_stby_en) && !mem_off_req) |=> (mem_main_en || mem_stby_en));

  assert_sw_off_R8: assert property (@(posedge clk) disable iff (rst)
    sw_off_req |=> (!sw_main_en && !sw_stby_en));

  assert_mem_off_R8: assert property (@(posedge clk) disable iff (rst)
    mem_off_req |=> (!mem_main_en && !mem_stby_en));

  assert_sw_abort_cause_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_abort[0] |-> $past(sw_off_req));

  assert_mem_abort_cause_R9: assert property (@(posedge clk) disable iff (rst)
    xfer_abort[1] |-> $past(mem_off_req));

  assert_mem_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_main_en) && mem_stby_en && !mem_off_req) |=> mem_stby_en);
endmodule

bind src_transfer_seq src_transfer_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sw_off_req  (sw_off_req),
  .mem_off_req (mem_off_req),
  .sw_main_en  (sw_main_en),
  .sw_stby_en  (sw_stby_en),
  .mem_main_en (mem_main_en),
  .mem_stby_en (mem_stby_en),
  .xfer_abort  (xfer_abort)
);

// File: tb/src_transfer_seq_tb.sv
module src_transfer_seq_tb;
  localparam int D = 50;
  localparam int O = 260;
  localparam int S_SWM = 0, S_SWS = 1, S_MM = 2, S_MS = 3, S_BSY = 4, S_AB0 = 5, S_AB1 = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_main_req = 1'b0, sw_off_req = 1'b0, mem_main_req = 1'b0, mem_off_req = 1'b0;
  logic sw_main_en, sw_stby_en, mem_main_en, mem_stby_en, busy;
  logic [1:0] xfer_abort;

  src_transfer_seq u_dut (
    .clk(clk), .rst(rst),
    .sw_main_req(sw_main_req), .sw_off_req(sw_off_req),
    .mem_main_req(mem_main_req), .mem_off_req(mem_off_req),
    .sw_main_en(sw_main_en), .sw_stby_en(sw_stby_en),
    .mem_main_en(mem_main_en), .mem_stby_en(mem_stby_en),
    .busy(busy), .xfer_abort(xfer_abort)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    logic  val;
    string req;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic mem_off_edge = 1'b0;
  logic mem_prev_on = 1'b0;

  always @(posedge clk) mem_off_edge <= mem_off_req;

  function automatic logic pick(int s);
    case (s)
      S_SWM:   return sw_main_en;
      S_SWS:   return sw_stby_en;
      S_MM:    return mem_main_en;
      S_MS:    return mem_stby_en;
      S_BSY:   return busy;
      S_AB0:   return xfer_abort[0];
      default: return xfer_abort[1];
    endcase
  endfunction

  task automatic expect_at(int at, int sig, logic val, string req);
    item_t it;
    it.at = at; it.sig = sig; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops due items and compares them, plus per-cycle rules.
  always @(posedge clk) begin
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        total++;
        if (pick(q[i].sig) !== q[i].val) begin
          bad++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%0b expected=%0b",
                   q[i].req, q[i].sig, cyc, pick(q[i].sig), q[i].val);
        end
        q.delete(i);
      end
    end
    if (!rst) begin
      total++;
      if (sw_main_en && sw_stby_en) begin
        bad++;
        $display("FAIL R3 cyc=%0d actual=both_on expected=exclusive", cyc);
      end
      if (mem_prev_on && !mem_off_edge) begin
        total++;
        if (!(mem_main_en || mem_stby_en)) begin
          bad++;
          $display("FAIL R6 cyc=%0d actual=0 expected=1", cyc);
        end
      end
    end
    mem_prev_on = mem_main_en || mem_stby_en;
  end

  initial begin
    int k, k2;
    tick(1);
    k = cyc;
    for (int s = 0; s <= S_AB1; s++) expect_at(k + 1, s, 1'b0, "R1");
    tick(3);

    // Release reset: immediate turn-on on standby.
    rst = 1'b0;
    k = cyc;
    expect_at(k + 1, S_SWS, 1'b1, "R2");
    expect_at(k + 1, S_SWM, 1'b0, "R2");
    expect_at(k + 1, S_MS, 1'b1, "R2");
    expect_at(k + 1, S_MM, 1'b0, "R2");
    expect_at(k + 1, S_BSY, 1'b0, "R2");
    tick(4);

    // Switched rail to main: dead time.
    sw_main_req = 1'b1;
    k = cyc;
    expect_at(k + 1, S_SWS, 1'b0, "R4");
    expect_at(k + 1, S_SWM, 1'b0, "R4");
    expect_at(k + 1, S_BSY, 1'b1, "R10");
    expect_at(k + D, S_SWM, 1'b0, "R4");
    expect_at(k + D, S_BSY, 1'b1, "R10");
    expect_at(k + 1 + D, S_SWM, 1'b1, "R4");
    expect_at(k + 1 + D, S_SWS, 1'b0, "R4");
    expect_at(k + 1 + D, S_BSY, 1'b0, "R10");
    tick(D + 5);

    // Memory rail to main: overlap.
    mem_main_req = 1'b1;
    k = cyc;
    expect_at(k + 1, S_MM, 1'b1, "R5");
    expect_at(k + 1, S_MS, 1'b1, "R5");
    expect_at(k + 1, S_BSY, 1'b1, "R10");
    expect_at(k + O, S_MS, 1'b1, "R5");
    expect_at(k + 1 + O, S_MS, 1'b0, "R5");
    expect_at(k + 1 + O, S_MM, 1'b1, "R5");
    expect_at(k + 1 + O, S_BSY, 1'b0, "R10");
    tick(O + 5);

    // Request flips back during a switched transfer.
    sw_main_req = 1'b0;
    k = cyc;
    expect_at(k + 10, S_SWM, 1'b0, "R7");
    expect_at(k + 10, S_SWS, 1'b0, "R7");
    expect_at(k + 1 + D, S_SWS, 1'b1, "R7");
    expect_at(k + 2 + D, S_SWS, 1'b0, "R7");
    expect_at(k + 2 + D, S_BSY, 1'b1, "R7");
    expect_at(k + 1 + 2 * D, S_SWM, 1'b0, "R7");
    expect_at(k + 2 + 2 * D, S_SWM, 1'b1, "R7");
    tick(5);
    sw_main_req = 1'b1;
    tick(2 * D + 10);

    // Off request ends a memory transfer.
    mem_main_req = 1'b0;
    k = cyc;
    expect_at(k + 1, S_MS, 1'b1, "R5");
    tick(10);
    mem_off_req = 1'b1;
    k2 = cyc;
    expect_at(k2 + 1, S_MM, 1'b0, "R8");
    expect_at(k2 + 1, S_MS, 1'b0, "R8");
    expect_at(k2 + 1, S_AB1, 1'b1, "R9");
    expect_at(k2 + 1, S_BSY, 1'b0, "R8");
    expect_at(k2 + 2, S_AB1, 1'b0, "R9");
    tick(5);
    mem_off_req = 1'b0;
    k = cyc;
    expect_at(k + 1, S_MS, 1'b1, "R2");
    expect_at(k + 1, S_MM, 1'b0, "R2");
    expect_at(k + 1, S_BSY, 1'b0, "R2");
    tick(5);

    // Off request in steady state on the switched rail (on main).
    sw_off_req = 1'b1;
    k = cyc;
    expect_at(k + 1, S_SWM, 1'b0, "R8");
    expect_at(k + 1, S_SWS, 1'b0, "R8");
    expect_at(k + 1, S_AB0, 1'b0, "R9");
    tick(3);
    sw_main_req = 1'b0;
    k = cyc;
    expect_at(k + 3, S_SWS, 1'b0, "R8");
    tick(5);
    sw_off_req = 1'b0;
    k = cyc;
    expect_at(k + 1, S_SWS, 1'b1, "R2");
    tick(5);

    // Both rails transfer together; busy covers the longer one.
    sw_main_req = 1'b1;
    mem_main_req = 1'b1;
    k = cyc;
    expect_at(k + 1 + D, S_SWM, 1'b1, "R4");
    expect_at(k + 1 + D, S_BSY, 1'b1, "R10");
    expect_at(k + O, S_BSY, 1'b1, "R10");
    expect_at(k + 1 + O, S_BSY, 1'b0, "R10");
    expect_at(k + 1 + O, S_MS, 1'b0, "R5");
    tick(O + 10);

    // Off request ends a switched transfer.
    sw_main_req = 1'b0;
    tick(3);
    sw_off_req = 1'b1;
    k2 = cyc;
    expect_at(k2 + 1, S_AB0, 1'b1, "R9");
    expect_at(k2 + 1, S_SWM, 1'b0, "R8");
    expect_at(k2 + 1, S_SWS, 1'b0, "R8");
    expect_at(k2 + 1, S_BSY, 1'b0, "R10");
    expect_at(k2 + 2, S_AB0, 1'b0, "R9");
    tick(3);
    sw_off_req = 1'b0;
    tick(5);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule